// File: doc/BRIEF.md
# SPI Register Access Master

This block carries out one complete register read or register write against an SPI peripheral that has a separate command-select line next to chip select. A request gives a direction, a 4-bit bank address, a transfer-size flag and 32 bits of write data. The master first sends a one-byte command frame with command-select high. It then releases chip select for a short gap and runs a data frame with command-select low. The data frame is four bytes long, or one byte long when the size flag is set.

On a write the data word goes out lowest byte first. On a read the returned bytes arrive highest byte first and are packed into a 32-bit result. The byte the peripheral returns during the command frame is kept as a status byte. During a full-width write the second byte returned in the data frame is the peripheral's echo of the command, and that byte is kept as well. The serial clock idles low. Its half period is set by a divider input, and a one-cycle completion pulse marks the end of each access.

Top module: `spi_regmaster`

## Requirements
- R1: The command byte is {write, 2'b00, bank[3:0], size}, where write = 1 selects a write and size = 1 selects the one-byte data frame. Bit 7 goes out first.
- R2: An access is two chip-select frames. The first frame is exactly one byte with cmd_sel high throughout. The second frame has cmd_sel low throughout. cs_n stays high for at least 2*(clk_div+1) clock cycles between the two frames. cs_n is low only while busy is high.
- R3: On a full-width write the data frame sends four bytes in the order wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24].
- R4: On a full-width read the four received bytes become rd_data[31:24], rd_data[23:16], rd_data[15:8] and rd_data[7:0], in order of arrival.
- R5: The byte received during the command frame appears on status once the access completes.
- R6: On a full-width write, the second byte received in the data frame appears on echo once the access completes.
- R7: A request with a bank above 10 is dropped. No frame is started, busy stays low and done does not pulse.
- R8: With size = 1 the data frame is one byte. A write sends wdata[31:24]. A read returns {byte, 24'h0} on rd_data.
- R9: Serial timing is mode 0. sclk idles low, bits go out MSB first, mosi changes only while sclk is low, and sclk has a half period of clk_div+1 clock cycles.
- R10: done is high for exactly one cycle per accepted access, and busy is low in that cycle. A request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial half period minus one, in clock cycles |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 4 | Register bank address, 0 to 10 |
| req_byte8 | input | 1 | 1 = one-byte data frame |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Assembled read value |
| status | output | 8 | Byte received in the command frame |
| echo | output | 8 | Command echo received during a full-width write |
| cs_n | output | 1 | Chip select, active low |
| cmd_sel | output | 1 | Command-select line, high during the command frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The assertions assume that clk_div stays constant for the whole of an access and that req_bank is known whenever req_valid is high. The bench meets both conditions: it changes the divider only while the block is idle, and it holds every request field steady for the single cycle of the strobe. The peripheral model drives miso only on falling sclk edges while chip select is low, so the value the master samples on the rising edge has settled.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int BANK_W     = 4;
    localparam int BANK_TOP   = 10;
    localparam int IDX_W      = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_DATA
    } seq_state_e;

    function automatic logic [BYTE_W-1:0] build_cmd(input logic wr,
                                                    input logic [BANK_W-1:0] bank,
                                                    input logic short_xfer);
        return {wr, 2'b00, bank, short_xfer};
    endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = en && !clr && (cnt_q == div);

    always_comb begin
        if (!en || clr || (cnt_q == div)) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
    import spi_regmaster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx,
    input  logic              tick,
    input  logic              miso,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx,
    output logic              done
);
    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic              done;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.sclk   = 1'b0;
                s_d.bitn   = '0;
                s_d.sh     = tx;
            end
        end else if (tick) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                s_d.rx   = {s_q.rx[BYTE_W-2:0], miso};
            end else begin
                s_d.sclk = 1'b0;
                if (s_q.bitn == BIT_W'(BYTE_W - 1)) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + 1'b1;
                    s_d.sh   = {s_q.sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign sclk   = s_q.sclk;
    assign mosi   = s_q.sh[BYTE_W-1];
    assign rx     = s_q.rx;
    assign done   = s_q.done;
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_regmaster_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_byte8,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] echo,
    output logic              cs_n,
    output logic              cmd_sel,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam logic [BANK_W-1:0] BANK_LIMIT = BANK_W'(BANK_TOP);
    localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(WORD_BYTES - 1);
    localparam logic [IDX_W-1:0]  IDX_ECHO   = IDX_W'(1);

    typedef struct packed {
        seq_state_e        state;
        logic              wr;
        logic              b8;
        logic [WORD_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic              gap;
        logic              start;
        logic [BYTE_W-1:0] txb;
        logic [WORD_W-1:0] rd;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] echo;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic              tick;
    logic              eng_active;
    logic              eng_done;
    logic [BYTE_W-1:0] eng_rx;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic wr, input logic b8,
                                                    input logic [WORD_W-1:0] wd,
                                                    input logic [IDX_W-1:0] idx);
        if (!wr)     return '0;
        else if (b8) return wd[WORD_W-1 -: BYTE_W];
        else         return wd[idx*BYTE_W +: BYTE_W];
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.done  = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid && (req_bank <= BANK_LIMIT)) begin
                    s_d.state = ST_CMD;
                    s_d.wr    = req_write;
                    s_d.b8    = req_byte8;
                    s_d.wdata = req_wdata;
                    s_d.idx   = '0;
                    s_d.start = 1'b1;
                    s_d.txb   = build_cmd(req_write, req_bank, req_byte8);
                    if (!req_write) s_d.rd = '0;
                end
            end
            ST_CMD: begin
                if (eng_done) begin
                    s_d.status = eng_rx;
                    s_d.state  = ST_GAP;
                    s_d.gap    = 1'b0;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (s_q.gap) begin
                        s_d.state = ST_DATA;
                        s_d.start = 1'b1;
                        s_d.txb   = pick_byte(s_q.wr, s_q.b8, s_q.wdata, '0);
                    end else begin
                        s_d.gap = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (eng_done) begin
                    if (!s_q.wr) begin
                        if (s_q.b8) s_d.rd = {eng_rx, {(WORD_W-BYTE_W){1'b0}}};
                        else        s_d.rd = {s_q.rd[WORD_W-BYTE_W-1:0], eng_rx};
                    end
                    if (s_q.wr && !s_q.b8 && (s_q.idx == IDX_ECHO)) s_d.echo = eng_rx;
                    if (s_q.b8 || (s_q.idx == IDX_LAST)) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.idx   = s_q.idx + 1'b1;
                        s_d.start = 1'b1;
                        s_d.txb   = pick_byte(s_q.wr, s_q.b8, s_q.wdata, s_q.idx + 1'b1);
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_active || (s_q.state == ST_GAP)),
        .clr   (s_q.start),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_byte_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (s_q.start),
        .tx     (s_q.txb),
        .tick   (tick),
        .miso   (miso),
        .active (eng_active),
        .sclk   (sclk),
        .mosi   (mosi),
        .rx     (eng_rx),
        .done   (eng_done)
    );

    assign busy    = (s_q.state != ST_IDLE);
    assign done    = s_q.done;
    assign rd_data = s_q.rd;
    assign status  = s_q.status;
    assign echo    = s_q.echo;
    assign cs_n    = !((s_q.state == ST_CMD) || (s_q.state == ST_DATA));
    assign cmd_sel = (s_q.state == ST_CMD);
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_bank,
    input logic       busy,
    input logic       done,
    input logic       cs_n,
    input logic       cmd_sel,
    input logic       sclk,
    input logic       mosi
);
    AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R2
    AST_CMDSEL_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n) cmd_sel |-> !cs_n); // R2
    AST_CMDSEL_STEADY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && !$past(cs_n)) |-> $stable(cmd_sel)); // R2
    AST_BAD_BANK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy && (req_bank > 4'd10)) |=> !busy); // R7
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R9
    AST_MOSI_STABLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .busy      (busy),
    .done      (done),
    .cs_n      (cs_n),
    .cmd_sel   (cmd_sel),
    .sclk      (sclk),
    .mosi      (mosi)
);

// File: tb/sim_spi_regmaster.sv
`timescale 1ns/1ps
module sim_spi_regmaster;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_bank = 4'd0;
    logic        req_byte8 = 1'b0;
    logic [31:0] req_wdata = 32'h0;
    logic        busy, done, cs_n, cmd_sel, sclk, mosi, miso;
    logic [31:0] rd_data;
    logic [7:0]  status, echo;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regmaster u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
        .req_write(req_write), .req_bank(req_bank), .req_byte8(req_byte8),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .status(status), .echo(echo), .cs_n(cs_n), .cmd_sel(cmd_sel),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // peripheral model
    int          frame_n = 0;
    int          s_bi = 0, s_bn = 0, s_bytes = 0;
    int          cmd_nbytes = 0, data_nbytes = 0;
    logic [7:0]  s_tx [4];
    logic [7:0]  s_rx [4];
    logic [7:0]  d_rx [4];
    logic [7:0]  s_cmd = 8'h0;
    logic [31:0] slv_val = 32'h0;
    logic [7:0]  slv_stat = 8'h0;
    bit          cmdsel_bad = 0;
    realtime     t_r0, t_r1;
    int          hi_cnt = 0, gap_meas = 0, done_cnt = 0;

    assign miso = (cs_n || s_bi > 3) ? 1'b0 : s_tx[s_bi][7 - s_bn];

    always @(negedge cs_n) begin
        s_bi = 0; s_bn = 0; s_bytes = 0;
        if (frame_n == 0) begin
            s_tx[0] = slv_stat;
        end else if (s_cmd[7]) begin
            s_tx[0] = slv_stat; s_tx[1] = s_cmd; s_tx[2] = 8'h00; s_tx[3] = 8'h00;
        end else begin
            s_tx[0] = slv_val[31:24]; s_tx[1] = slv_val[23:16];
            s_tx[2] = slv_val[15:8];  s_tx[3] = slv_val[7:0];
        end
        if (frame_n == 1) gap_meas = hi_cnt;
    end

    always @(posedge cs_n) begin
        if (frame_n == 0) begin
            cmd_nbytes = s_bytes; s_cmd = s_rx[0];
        end else if (frame_n == 1) begin
            data_nbytes = s_bytes;
            for (int i = 0; i < 4; i++) d_rx[i] = s_rx[i];
        end
        frame_n++;
        hi_cnt = 0;
    end

    always @(posedge sclk) if (!cs_n) begin
        if (s_bi < 4) s_rx[s_bi][7 - s_bn] = mosi;
        if (frame_n == 0 && !cmd_sel) cmdsel_bad = 1;
        if (frame_n == 1 && cmd_sel) cmdsel_bad = 1;
        if (frame_n == 1 && s_bytes == 0 && s_bn == 0) t_r0 = $realtime;
        if (frame_n == 1 && s_bytes == 0 && s_bn == 1) t_r1 = $realtime;
    end

    always @(negedge sclk) if (!cs_n) begin
        s_bn++;
        if (s_bn == 8) begin s_bn = 0; s_bi++; s_bytes++; end
    end

    always @(negedge clk) begin
        if (cs_n) hi_cnt++;
        if (done) done_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic issue(input logic wr, input logic [3:0] bank, input logic b8,
                         input logic [31:0] wd);
        @(negedge clk);
        req_write = wr; req_bank = bank; req_byte8 = b8; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk("R10 busy low at done", {31'h0, busy}, 32'h0);
        repeat (4) @(negedge clk);
    endtask

    task automatic prep(input int div, input logic [7:0] st, input logic [31:0] val);
        @(negedge clk);
        clk_div = 8'(div); slv_stat = st; slv_val = val;
        frame_n = 0; done_cnt = 0; cmdsel_bad = 0;
    endtask

    task automatic t_reset();
        chk("R2 reset cs_n high", {31'h0, cs_n}, 32'h1);
        chk("R9 reset sclk low", {31'h0, sclk}, 32'h0);
        chk("R10 reset busy low", {31'h0, busy}, 32'h0);
        chk("R10 reset done low", {31'h0, done}, 32'h0);
        chk("R2 reset cmd_sel low", {31'h0, cmd_sel}, 32'h0);
    endtask

    task automatic t_write32(input logic [3:0] bank, input logic [31:0] wd,
                             input logic [7:0] st, input int div);
        logic [7:0] ec;
        ec = {1'b1, 2'b00, bank, 1'b0};
        prep(div, st, 32'h0);
        issue(1'b1, bank, 1'b0, wd);
        wait_done();
        chk("R1 write command byte", {24'h0, s_cmd}, {24'h0, ec});
        chk("R2 command frame one byte", cmd_nbytes, 1);
        chk("R2 cmd_sel per frame", {31'h0, cmdsel_bad}, 32'h0);
        chk("R2 gap length ok", {31'h0, gap_meas >= 2*(div+1)}, 32'h1);
        chk("R3 data frame four bytes", data_nbytes, 4);
        chk("R3 write byte order", {d_rx[3], d_rx[2], d_rx[1], d_rx[0]}, wd);
        chk("R5 status latched", {24'h0, status}, {24'h0, st});
        chk("R6 echo latched", {24'h0, echo}, {24'h0, ec});
        chk("R10 single done pulse", done_cnt, 1);
    endtask

    task automatic t_read32(input logic [3:0] bank, input logic [31:0] val,
                            input logic [7:0] st, input int div);
        prep(div, st, val);
        issue(1'b0, bank, 1'b0, 32'hFFFF_FFFF);
        wait_done();
        chk("R1 read command byte", {24'h0, s_cmd}, {24'h0, 1'b0, 2'b00, bank, 1'b0});
        chk("R4 data frame four bytes", data_nbytes, 4);
        chk("R4 read assembly", rd_data, val);
        chk("R5 status latched on read", {24'h0, status}, {24'h0, st});
        chk("R9 sclk period", int'((t_r1 - t_r0) / 1.0), 2*(div+1)*CLK_PERIOD);
        chk("R3 read sends zero bytes", {d_rx[0], d_rx[1], d_rx[2], d_rx[3]}, 32'h0);
        chk("R10 single done pulse read", done_cnt, 1);
    endtask

    task automatic t_write8(input logic [3:0] bank, input logic [31:0] wd);
        prep(2, 8'h11, 32'h0);
        issue(1'b1, bank, 1'b1, wd);
        wait_done();
        chk("R1 short write command", {24'h0, s_cmd}, {24'h0, 1'b1, 2'b00, bank, 1'b1});
        chk("R8 short write one byte", data_nbytes, 1);
        chk("R8 short write sends top byte", {24'h0, d_rx[0]}, {24'h0, wd[31:24]});
    endtask

    task automatic t_read8(input logic [3:0] bank, input logic [31:0] val);
        prep(0, 8'h22, val);
        issue(1'b0, bank, 1'b1, 32'h0);
        wait_done();
        chk("R1 short read command", {24'h0, s_cmd}, {24'h0, 1'b0, 2'b00, bank, 1'b1});
        chk("R8 short read one byte", data_nbytes, 1);
        chk("R8 short read value", rd_data, {val[31:24], 24'h0});
    endtask

    task automatic t_reject(input logic [3:0] bank);
        bit seen_busy = 0;
        prep(1, 8'h00, 32'h0);
        issue(1'b1, bank, 1'b0, 32'h1234_5678);
        repeat (60) begin @(negedge clk); if (busy) seen_busy = 1; end
        chk("R7 no frame for bad bank", frame_n, 0);
        chk("R7 busy stays low", {31'h0, seen_busy}, 32'h0);
        chk("R7 no done for bad bank", done_cnt, 0);
    endtask

    task automatic t_ignore_busy();
        prep(1, 8'h44, 32'h0);
        issue(1'b1, 4'd2, 1'b0, 32'hDEAD_BEEF);
        repeat (30) @(negedge clk);
        chk("R10 busy during access", {31'h0, busy}, 32'h1);
        issue(1'b1, 4'd3, 1'b0, 32'h0102_0304);
        wait_done();
        repeat (150) @(negedge clk);
        chk("R10 first command kept", {24'h0, s_cmd}, 32'h0000_0084);
        chk("R10 first data kept", {d_rx[3], d_rx[2], d_rx[1], d_rx[0]}, 32'hDEAD_BEEF);
        chk("R10 no second access", frame_n, 2);
        chk("R10 one done only", done_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_write32(4'd1, 32'h2850_0600, 8'h03, 1);
        t_read32(4'd1, 32'h2850_0600, 8'h03, 1);
        t_read32(4'd10, 32'hA5C3_0F81, 8'h5A, 3);
        t_write32(4'd9, 32'h8001_7FFE, 8'hC0, 0);
        t_write8(4'd0, 32'h9A00_0077);
        t_read8(4'd9, 32'hB6AA_5511);
        t_reject(4'd11);
        t_reject(4'd15);
        t_ignore_busy();
        summary();
        $finish;
    end
endmodule